// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire serial slave that gives a bus master read and write access to a small bank of byte-wide configuration registers. The register outputs appear as one flat parallel vector that drives enable controls elsewhere on the chip. Every register loads a parameterized default on reset, so the system works without any bus traffic. The master only uses the interface when a setting has to change.

The bus lines are sampled by the block's own system clock. The data line is driven only through an open-drain enable: when `sdaOe` is high, the pad pulls SDA low. The block detects start and stop conditions and answers one fixed 7-bit address. The command byte that follows picks one of two access types: a single indexed byte, or a sequential block starting at register zero. The block then moves data bytes most significant bit first. A block write carries a byte count after the command. A block read returns a byte count before the data. A read of either kind starts with a write of the command, followed by a repeated start and the address with the read bit set.

Top module: `smbRegSlave`

## Requirements
- R1: On reset every register takes its byte of the `DEFAULTS` parameter (register i from bits 8i+7..8i), and the slave leaves SDA released.
- R2: The slave acknowledges an address byte whose upper seven bits equal `SLAVE_ADDR` (default 1101001, so D2h to write and D3h to read; bit 0 is R/W with 0 = write). For any other address it returns NACK and leaves the bus and the registers alone until the next start.
- R3: If command bit 7 is 1, the access is a single byte at the offset in bits 6:0. If bit 7 is 0, the access is a block starting at register 0, whatever bits 6:0 hold.
- R4: A byte command whose offset is not below `NUM_REGS` is NACKed. Every later byte of that transaction is NACKed and has no effect.
- R5: A byte write (address, command, one data byte) stores and ACKs the data byte. Any further data byte in the same transaction is NACKed and discarded.
- R6: A byte read (command write, repeated start, address with R/W = 1) returns the addressed register MSB first.
- R7: A block write ACKs a count byte after the command. It then stores data bytes into registers 0, 1, 2… in ascending order. A byte beyond the count, or beyond the last register, is NACKed and not stored.
- R8: A stop after any complete byte ends the transaction. Bytes already ACKed stay stored, and every other register keeps its value.
- R9: A block read returns `NUM_REGS` as its first byte, then registers from 0 upward. A byte read past the last register reads as 00h.
- R10: When the master NACKs a read byte, the slave stops transmitting and keeps SDA released until the next start or stop.
- R11: The slave changes its SDA drive only while SCL is low. It releases SDA at every start and stop condition and whenever it is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad (wired-AND level) |
| sdaOe | output | 1 | Open-drain pull-down enable for the data line |
| regFlat | output | NUM_REGS*8 | Register bank, register i in bits 8i+7..8i |

## Verification
The bench targets block writes whose count is zero, matches the bank size, or runs past it. A design that ignores the count would overwrite registers it was never asked to change, or would ACK bytes it drops. Early stops in the middle of a block write check that earlier bytes stay committed. A design that buffers the data until the end would lose them. Block reads run past the last register and must return 00h; a design with a wrapping pointer would instead repeat register 0. Block commands carry nonzero offset bits; a design that honours those bits would write from the wrong start. After a master NACK, the bench clocks another byte and expects all ones on the line. A slave that keeps transmitting would pull bits low there. The bench also checks that SDA never moves while SCL is high, which a design that updates its drive on the rising edge would violate.

// File: rtl/smbSlvPkg.sv
package smbSlvPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_COUNT,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } slvState_t;

  // Bus events seen by the datapath
  typedef struct packed {
    logic startEv;
    logic stopEv;
    logic byteRx;   // eighth bit received, ack slot begins
    logic ackEnd;   // ninth clock finished
  } busEvent_t;

  // Strobes from control into datapath
  typedef struct packed {
    logic ackByte;
    logic latchCmd;
    logic setCount;
    logic writeReg;
    logic loadCountTx;
    logic loadRegTx;
    logic stopTx;
  } ctrlStrobe_t;

endpackage

// File: rtl/smbSlvDatapath.sv
module smbSlvDatapath
  import smbSlvPkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter logic [NUM_REGS*8-1:0] DEFAULTS = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  ctrlStrobe_t           strobe,
  output busEvent_t             evt,
  output logic [7:0]            rxByte,
  output logic                  ackSampled,
  output logic                  ptrInRange,
  output logic                  cntEmpty,
  output logic                  sclSync,
  output logic                  sdaOe,
  output logic [NUM_REGS*8-1:0] regFlat
);

  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [7:0] BANK_SIZE = 8'(NUM_REGS);

  logic sclQ, sdaQ, sclPrev, sdaPrev;
  logic sclRise, sclFall, frameClr;
  logic [3:0] bitCnt;
  logic ackPhase, ackDrive, txActive;
  logic [7:0] shiftReg, txShift, ptr, cntLeft, regByte;
  logic [NUM_REGS-1:0][7:0] regArr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclQ <= 1'b1; sdaQ <= 1'b1; sclPrev <= 1'b1; sdaPrev <= 1'b1;
    end else begin
      sclQ <= sclIn; sdaQ <= sdaIn; sclPrev <= sclQ; sdaPrev <= sdaQ;
    end
  end

  assign sclSync     = sclQ;
  assign sclRise     = sclQ & ~sclPrev;
  assign sclFall     = ~sclQ & sclPrev;
  assign evt.startEv = sclQ & sclPrev & sdaPrev & ~sdaQ;
  assign evt.stopEv  = sclQ & sclPrev & ~sdaPrev & sdaQ;
  assign evt.byteRx  = sclFall & (bitCnt == LAST_BIT) & ~ackPhase;
  assign evt.ackEnd  = sclFall & ackPhase;
  assign frameClr    = evt.startEv | evt.stopEv;

  // Bit engine: eight data clocks then one acknowledge clock
  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt <= '0; ackPhase <= 1'b0; shiftReg <= '0; ackSampled <= 1'b1;
    end else if (frameClr) begin
      bitCnt <= '0; ackPhase <= 1'b0;
    end else begin
      if (sclRise) begin
        if (bitCnt != LAST_BIT) begin
          shiftReg <= {shiftReg[6:0], sdaQ};
          bitCnt   <= bitCnt + 4'd1;
        end else begin
          ackSampled <= sdaQ;
        end
      end
      if (sclFall) begin
        if (ackPhase) begin
          ackPhase <= 1'b0;
          bitCnt   <= '0;
        end else if (bitCnt == LAST_BIT) begin
          ackPhase <= 1'b1;
        end
      end
    end
  end

  assign rxByte = shiftReg;

  // Acknowledge drive and transmit shifter, updated on falling SCL only
  always_ff @(posedge clk) begin
    if (rst || frameClr) begin
      ackDrive <= 1'b0; txActive <= 1'b0; txShift <= 8'hFF;
    end else begin
      if (strobe.ackByte)  ackDrive <= 1'b1;
      else if (evt.ackEnd) ackDrive <= 1'b0;
      if (strobe.loadCountTx) begin
        txShift <= BANK_SIZE; txActive <= 1'b1;
      end else if (strobe.loadRegTx) begin
        txShift <= regByte; txActive <= 1'b1;
      end else if (strobe.stopTx) begin
        txActive <= 1'b0;
      end else if (sclFall && !ackPhase && bitCnt != 4'd0 && bitCnt != LAST_BIT) begin
        txShift <= {txShift[6:0], 1'b1};
      end
    end
  end

  assign sdaOe = ackDrive | (txActive & ~ackPhase & ~txShift[7]);

  // Register pointer and remaining-byte counter
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0; cntLeft <= '0;
    end else begin
      if (strobe.latchCmd) begin
        ptr     <= shiftReg[7] ? {1'b0, shiftReg[6:0]} : 8'd0;
        cntLeft <= {7'd0, shiftReg[7]};
      end else if (strobe.setCount) begin
        cntLeft <= shiftReg;
      end else if (strobe.writeReg || strobe.loadRegTx) begin
        if (ptr != 8'hFF) ptr <= ptr + 8'd1;
        if (strobe.writeReg) cntLeft <= cntLeft - 8'd1;
      end
    end
  end

  assign ptrInRange = (ptr < BANK_SIZE);
  assign cntEmpty   = (cntLeft == 8'd0);

  always_comb begin
    regByte = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (ptr == 8'(i)) regByte = regArr[i];
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regArr[g] <= DEFAULTS[g*8 +: 8];
      else if (strobe.writeReg && ptr == 8'(g)) regArr[g] <= shiftReg;
    end
  end

  assign regFlat = regArr;

endmodule

// File: rtl/smbSlvCtrl.sv
module smbSlvCtrl
  import smbSlvPkg::*;
#(
  parameter int         NUM_REGS   = 8,
  parameter logic [6:0] SLAVE_ADDR = 7'h69
) (
  input  logic        clk,
  input  logic        rst,
  input  busEvent_t   evt,
  input  logic [7:0]  rxByte,
  input  logic        ackSampled,
  input  logic        ptrInRange,
  input  logic        cntEmpty,
  output ctrlStrobe_t strobe,
  output slvState_t   state
);

  slvState_t nextState;
  logic blockMode, firstTx;

  always_comb begin
    strobe    = '0;
    nextState = state;
    if (evt.startEv) begin
      nextState = ST_ADDR;
    end else if (evt.stopEv) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_ADDR: if (evt.byteRx) begin
          if (rxByte[7:1] == SLAVE_ADDR) begin
            strobe.ackByte = 1'b1;
            nextState = rxByte[0] ? ST_RDATA : ST_CMD;
          end else begin
            nextState = ST_IGNORE;
          end
        end
        ST_CMD: if (evt.byteRx) begin
          if (rxByte[7] && ({1'b0, rxByte[6:0]} >= 8'(NUM_REGS))) begin
            nextState = ST_IGNORE;
          end else begin
            strobe.ackByte  = 1'b1;
            strobe.latchCmd = 1'b1;
            nextState = rxByte[7] ? ST_WDATA : ST_COUNT;
          end
        end
        ST_COUNT: if (evt.byteRx) begin
          strobe.ackByte  = 1'b1;
          strobe.setCount = 1'b1;
          nextState = ST_WDATA;
        end
        ST_WDATA: if (evt.byteRx) begin
          if (!cntEmpty && ptrInRange) begin
            strobe.ackByte  = 1'b1;
            strobe.writeReg = 1'b1;
          end else begin
            nextState = ST_IGNORE;
          end
        end
        ST_RDATA: if (evt.ackEnd) begin
          if (firstTx) begin
            if (blockMode) strobe.loadCountTx = 1'b1;
            else           strobe.loadRegTx   = 1'b1;
          end else if (!ackSampled) begin
            strobe.loadRegTx = 1'b1;
          end else begin
            strobe.stopTx = 1'b1;
            nextState = ST_IGNORE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; blockMode <= 1'b0; firstTx <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.latchCmd) blockMode <= ~rxByte[7];
      if (state == ST_ADDR && nextState == ST_RDATA) firstTx <= 1'b1;
      else if (state == ST_RDATA && evt.ackEnd)      firstTx <= 1'b0;
    end
  end

endmodule

// File: rtl/smbRegSlave.sv
module smbRegSlave
  import smbSlvPkg::*;
#(
  parameter int                    NUM_REGS   = 8,
  parameter logic [6:0]            SLAVE_ADDR = 7'h69,
  parameter logic [NUM_REGS*8-1:0] DEFAULTS   = 64'h8765_4321_FEDC_BA98
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic [NUM_REGS*8-1:0] regFlat
);

  busEvent_t   evt;
  ctrlStrobe_t strobe;
  slvState_t   ctrlState;
  logic [7:0]  rxByte;
  logic        ackSampled, ptrInRange, cntEmpty, sclSync;

  smbSlvDatapath #(.NUM_REGS(NUM_REGS), .DEFAULTS(DEFAULTS)) dp_i (
    .clk(clk), .rst(rst), .sclIn(sclIn), .sdaIn(sdaIn), .strobe(strobe),
    .evt(evt), .rxByte(rxByte), .ackSampled(ackSampled),
    .ptrInRange(ptrInRange), .cntEmpty(cntEmpty), .sclSync(sclSync),
    .sdaOe(sdaOe), .regFlat(regFlat)
  );

  smbSlvCtrl #(.NUM_REGS(NUM_REGS), .SLAVE_ADDR(SLAVE_ADDR)) ctrl_i (
    .clk(clk), .rst(rst), .evt(evt), .rxByte(rxByte),
    .ackSampled(ackSampled), .ptrInRange(ptrInRange), .cntEmpty(cntEmpty),
    .strobe(strobe), .state(ctrlState)
  );

endmodule

// File: rtl/smbRegSlaveChk.sv
module smbRegSlaveChk
  import smbSlvPkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  sclSync,
  input logic                  startEv,
  input logic                  stopEv,
  input slvState_t             ctrlState,
  input logic                  sdaOe,
  input logic [NUM_REGS*8-1:0] regFlat
);

  // R11
  sda_stable_high_chk: assert property (@(posedge clk) disable iff (rst)
    (sclSync && $past(sclSync)) |-> $stable(sdaOe));

  // R11
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    startEv |=> !sdaOe);

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stopEv |=> !sdaOe);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrlState == ST_IDLE) |-> !sdaOe);

  // R7
  write_acked_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(regFlat) |-> sdaOe);

endmodule

bind smbRegSlave smbRegSlaveChk #(.NUM_REGS(NUM_REGS)) chk_i (
  .clk(clk), .rst(rst), .sclSync(sclSync), .startEv(evt.startEv),
  .stopEv(evt.stopEv), .ctrlState(ctrlState), .sdaOe(sdaOe), .regFlat(regFlat)
);

// File: tb/smbRegSlave_tb_top.sv
module smbRegSlave_tb_top;

  localparam int N = 8;
  localparam logic [N*8-1:0] DEF = 64'h8765_4321_FEDC_BA98;
  localparam int Q = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe, sdaLine;
  logic [N*8-1:0] regFlat;

  int nChecks = 0, nFails = 0, highViol = 0;
  logic [7:0] model [N];

  always #5 clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  smbRegSlave #(.NUM_REGS(N), .SLAVE_ADDR(7'h69), .DEFAULTS(DEF)) dut_i (
    .clk(clk), .rst(rst), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .regFlat(regFlat)
  );

  function automatic logic [N*8-1:0] packModel();
    logic [N*8-1:0] v;
    for (int i = 0; i < N; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  function automatic logic [7:0] expRead(input int idx);
    return (idx < N) ? model[idx] : 8'h00;
  endfunction

  function automatic logic expBlockAck(input int j, input int cnt);
    return (j < cnt) && (j < N);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ();
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitQ(); sclM = 1'b1; waitQ(); waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    b = sdaLine; waitQ();
    if (sdaLine !== b) highViol++;
    sclM = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(a);
    acked = ~a;
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin recvBit(b); d[i] = b; end
    sendBit(~giveAck);
  endtask

  task automatic doByteWrite(input int off, input logic [7:0] d, input string req);
    logic a; logic ok;
    ok = (off < N);
    busStart();
    sendByte(8'hD2, a);                 check({req, " addr ack"}, a, 1'b1);
    sendByte(8'h80 | 8'(off), a);       check({req, " cmd ack"}, a, ok);
    sendByte(d, a);                     check({req, " data ack"}, a, ok);
    busStop();
    if (ok) model[off] = d;
    check({req, " bank"}, regFlat, packModel());
  endtask

  task automatic doByteRead(input int off, input string req);
    logic a; logic [7:0] v;
    busStart();
    sendByte(8'hD2, a);
    sendByte(8'h80 | 8'(off), a);       check({req, " cmd ack"}, a, 1'b1);
    busStart();
    sendByte(8'hD3, a);                 check({req, " read addr ack"}, a, 1'b1);
    recvByte(1'b0, v);                  check({req, " data"}, v, expRead(off));
    busStop();
  endtask

  task automatic doBlockWrite(input logic [6:0] low, input int cnt, input int k, input string req);
    logic a; logic [7:0] d;
    busStart();
    sendByte(8'hD2, a);
    sendByte({1'b0, low}, a);           check({req, " block cmd ack"}, a, 1'b1);
    sendByte(8'(cnt), a);               check({req, " count ack"}, a, 1'b1);
    for (int j = 0; j < k; j++) begin
      d = 8'($urandom);
      sendByte(d, a);                   check({req, " block data ack"}, a, expBlockAck(j, cnt));
      if (expBlockAck(j, cnt)) model[j] = d;
    end
    busStop();
    check({req, " bank"}, regFlat, packModel());
  endtask

  task automatic doBlockRead(input int extra, input string req);
    logic a; logic [7:0] v;
    int total;
    total = N + extra;
    busStart();
    sendByte(8'hD2, a);
    sendByte(8'h00, a);
    busStart();
    sendByte(8'hD3, a);                 check({req, " read addr ack"}, a, 1'b1);
    recvByte(1'b1, v);                  check("R9 count byte", v, 8'(N));
    for (int j = 0; j < total; j++) begin
      recvByte(j != total - 1, v);      check({req, " block data"}, v, expRead(j));
    end
    busStop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic a; logic [7:0] v; logic [7:0] d1;
    void'($urandom(32'h5A17));
    for (int i = 0; i < N; i++) model[i] = DEF[i*8 +: 8];
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 reset bank", regFlat, DEF);
    check("R1 reset sda released", sdaOe, 1'b0);

    // R2 foreign address ignored for the rest of the transaction
    busStart();
    sendByte(8'hA4, a);                 check("R2 foreign addr nack", a, 1'b0);
    sendByte(8'h81, a);                 check("R2 ignored cmd", a, 1'b0);
    sendByte(8'h55, a);                 check("R2 ignored data", a, 1'b0);
    busStop();
    check("R2 bank unchanged", regFlat, packModel());

    // R3 R5 directed byte writes at both ends
    doByteWrite(0, 8'h3C, "R3 R5 first reg");
    doByteWrite(N - 1, 8'hC3, "R3 R5 last reg");

    // R5 second data byte in a byte write
    d1 = 8'h6E;
    busStart();
    sendByte(8'hD2, a);
    sendByte(8'h83, a);
    sendByte(d1, a);                    check("R5 first data ack", a, 1'b1);
    sendByte(8'h11, a);                 check("R5 extra byte nack", a, 1'b0);
    busStop();
    model[3] = d1;
    check("R5 extra byte discarded", regFlat, packModel());

    // R4 offset out of range
    doByteWrite(N, 8'hEE, "R4 offset range");

    // R6 byte reads
    for (int i = 0; i < N; i++) doByteRead(i, "R6 byte read");

    // R10 release after master nack
    busStart();
    sendByte(8'hD2, a);
    sendByte(8'h82, a);
    busStart();
    sendByte(8'hD3, a);
    recvByte(1'b0, v);                  check("R10 byte before nack", v, expRead(2));
    recvByte(1'b0, v);                  check("R10 line released", v, 8'hFF);
    busStop();

    // R7 full block write plus one extra byte
    doBlockWrite(7'd0, N, N + 1, "R7 full block");
    // R7 count shorter than bank, one byte beyond count
    doBlockWrite(7'd0, 3, 4, "R7 count limit");
    // R7 zero count
    doBlockWrite(7'd0, 0, 1, "R7 zero count");
    // R7 count larger than the bank
    doBlockWrite(7'd0, N + 2, N + 1, "R7 past bank");
    // R3 block command with nonzero offset bits starts at register 0
    doBlockWrite(7'h05, 2, 2, "R3 block offset bits");
    // R8 stop early in a block write
    doBlockWrite(7'd0, 5, 2, "R8 early stop");
    doBlockWrite(7'd0, 6, 0, "R8 stop after count");

    // R9 block read past the bank
    doBlockRead(2, "R9 block read");

    // Random mix
    for (int it = 0; it < 25; it++) begin
      int op; int c;
      op = int'($urandom % 4);
      case (op)
        0: doByteWrite(int'($urandom % (N + 1)), 8'($urandom), "R5 random write");
        1: doByteRead(int'($urandom % N), "R6 random read");
        2: begin
          c = int'($urandom % (N + 3));
          doBlockWrite(7'($urandom), c, int'($urandom % (c + 2)), "R7 R8 random block write");
        end
        default: doBlockRead(int'($urandom % 3), "R9 random block read");
      endcase
    end

    // R11 the slave never moved SDA while SCL was high
    check("R11 sda stable while scl high", highViol, 0);
    finishRun();
  end

endmodule